// File: doc/BRIEF.md
# Bus Address Resolution Unit

This block works out the slave addresses that a power-management device answers on its two serial management interfaces: a plain I2C register port and a PMBus command port. Software keeps a base address for each interface in one configuration register. A lock register can protect that register from writes. An option bit adds a board-level strap offset to both bases. The offset comes from a resistor strap. An ADC digitises the strap, and the block turns the ADC code into a number from 0 to 15. It takes this number once, when a fixed measurement window after reset ends, and keeps it until the next reset.

Each address is the base plus the offset. If the sum goes past 7Fh, the address saturates at 7Fh and a sticky error flag is set. A base of zero switches its interface off. An effective address that falls in the reserved set is flagged as illegal. A test pin is sampled while reset is held. If it is high, the I2C address is forced to 0Ah and the stored configuration is not loaded, so the registers come up cleared instead of at their defaults. Each interface also gets an enable output, so the protocol engines can simply follow these outputs.

Top module: `bus_addr_resolver`

## Requirements
- R1: After reset, with the test pin low, the base registers hold 10h for I2C and 40h for PMBus. The offset option is on, so the outputs read 10h+offset and 40h+offset once ready_o is high.
- R2: A write with wr_sel=0 loads the PMBus base from wr_data[6:0] and the I2C base from wr_data[14:8]. wr_data bits 7 and 15 are ignored.
- R3: A write with wr_sel=1 stores wr_data[2] as the lock bit, which resets to 1. While the lock bit is 1, writes with wr_sel=0 leave both bases unchanged.
- R4: A write with wr_sel=2 stores wr_data[0] as the offset option. When it is 0, both addresses equal their bases with no offset added.
- R5: The strap offset is captured exactly WIN_CYCLES clock edges after reset is released. ready_o rises one edge later. After that, changes on adc_code have no effect until the next reset.
- R6: The offset equals the number of k in 1..15 for which adc_code >= k*2^(ADC_W-4) - 2^(ADC_W-5). With ADC_W=10, codes 0..31 give 0, code 32 gives 1, code 64*k gives k, and code 1023 gives 15.
- R7: If base plus offset is greater than 7Fh on an enabled interface, that address reads 7Fh and clamp_err_o is set. clamp_err_o stays set until reset. A sum of exactly 7Fh (for example 77h+8) does not set it.
- R8: A base of 0 disables its interface on its own: the enable, the address and the illegal flag of that interface all read 0.
- R9: On an enabled, non-forced interface, the illegal flag is 1 exactly when the effective address is in 01h..07h, 0Ah or 0Ch.
- R10: If test_pin is high during reset, i2c_addr_o reads 0Ah with i2c_en_o=1 and i2c_bad_o=0, whatever is written later. Both bases reset to 0 and the offset option resets to 0.
- R11: Every output is registered and reflects a register write on the second clock edge after the write is presented. Before ready_o is high, all enables and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples test_pin |
| test_pin | input | 1 | Test-mode strap, sampled while rst is high |
| adc_code | input | ADC_W | Digitised strap voltage |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 base addresses, 1 lock, 2 option |
| wr_data | input | 16 | Write data |
| i2c_addr_o | output | 7 | Effective I2C address |
| pmb_addr_o | output | 7 | Effective PMBus address |
| i2c_en_o | output | 1 | I2C interface enabled |
| pmb_en_o | output | 1 | PMBus interface enabled |
| i2c_bad_o | output | 1 | I2C address is reserved |
| pmb_bad_o | output | 1 | PMBus address is reserved |
| clamp_err_o | output | 1 | Sticky saturation error |
| ready_o | output | 1 | Strap offset captured, outputs valid |
| offset_o | output | 4 | Captured strap offset |

## Verification
A register write presented before clock edge E changes the register at E. The outputs show the change at edge E+1, so the bench drives on falling edges and samples on the falling edge after E+1.

The offset is captured at edge WIN_CYCLES after reset release, and ready_o and the addresses appear one edge later. The bench therefore checks that ready_o is still low after WIN_CYCLES falling edges and that the expected addresses are present one falling edge after that.

Strap changes made after capture are checked after several idle cycles, to confirm they have no effect.

// File: rtl/addr_pkg.sv
package addr_pkg;
  localparam int ADDR_W   = 7;
  localparam int REG_W    = 16;
  localparam int LOCK_BIT = 2;
  localparam int OPT_BIT  = 0;
  localparam int PMB_LSB  = 0;
  localparam int I2C_LSB  = 8;
  localparam int N_LANE   = 2;
  localparam int LANE_PMB = 0;
  localparam int LANE_I2C = 1;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_OPT  = 2'd2
  } reg_sel_e;

  localparam addr_t ADDR_MAX = '1;

  function automatic logic is_reserved(input addr_t a);
    return ((a >= addr_t'(7'h01)) && (a <= addr_t'(7'h07))) ||
           (a == addr_t'(7'h0A)) || (a == addr_t'(7'h0C));
  endfunction
endpackage

// File: rtl/addr_cfg_regs.sv
module addr_cfg_regs
  import addr_pkg::*;
#(
  parameter addr_t DEF_I2C = 7'h10,
  parameter addr_t DEF_PMB = 7'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output addr_t            i2c_base_q,
  output addr_t            pmb_base_q,
  output logic             lock_q,
  output logic             opt_q,
  output logic             test_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      test_q     <= test_pin;
      i2c_base_q <= test_pin ? '0 : DEF_I2C;
      pmb_base_q <= test_pin ? '0 : DEF_PMB;
      opt_q      <= ~test_pin;
      lock_q     <= 1'b1;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_BASE: if (!lock_q) begin
          i2c_base_q <= wr_data[I2C_LSB +: ADDR_W];
          pmb_base_q <= wr_data[PMB_LSB +: ADDR_W];
        end
        SEL_LOCK: lock_q <= wr_data[LOCK_BIT];
        SEL_OPT:  opt_q  <= wr_data[OPT_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/strap_offset_latch.sv
module strap_offset_latch #(
  parameter int ADC_W      = 10,
  parameter int OFF_W      = 4,
  parameter int WIN_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADC_W-1:0] adc_code,
  output logic [OFF_W-1:0] offset_q,
  output logic             ready_q
);
  localparam int NSTEP = 2 ** OFF_W;
  localparam int STEP  = 2 ** (ADC_W - OFF_W);
  localparam int HALF  = STEP / 2;
  localparam int CW    = $clog2(WIN_CYCLES + 1);

  logic [NSTEP-1:1] hit;
  logic [OFF_W-1:0] mapped;
  logic [CW-1:0]    cnt;

  for (genvar k = 1; k < NSTEP; k++) begin : g_thr
    localparam logic [ADC_W:0] THR = (ADC_W+1)'(k * STEP - HALF);
    assign hit[k] = ({1'b0, adc_code} >= THR);
  end

  always_comb begin
    mapped = '0;
    for (int k = 1; k < NSTEP; k++) mapped = mapped + OFF_W'(hit[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ready_q  <= 1'b0;
      offset_q <= '0;
    end else if (!ready_q) begin
      if (cnt == CW'(WIN_CYCLES - 1)) begin
        ready_q  <= 1'b1;
        offset_q <= mapped;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_lane.sv
module addr_lane
  import addr_pkg::*;
#(
  parameter int    OFF_W      = 4,
  parameter addr_t FORCE_ADDR = 7'h0A
) (
  input  addr_t            base,
  input  logic [OFF_W-1:0] offset,
  input  logic             opt_en,
  input  logic             force_en,
  output addr_t            eff,
  output logic             en,
  output logic             bad,
  output logic             clamp
);
  logic [ADDR_W:0] sum;

  always_comb begin
    sum   = {1'b0, base} + (ADDR_W+1)'(opt_en ? offset : '0);
    eff   = '0;
    en    = 1'b0;
    bad   = 1'b0;
    clamp = 1'b0;
    if (force_en) begin
      eff = FORCE_ADDR;
      en  = 1'b1;
    end else if (base != '0) begin
      en    = 1'b1;
      clamp = sum[ADDR_W];
      eff   = clamp ? ADDR_MAX : sum[ADDR_W-1:0];
      bad   = is_reserved(eff);
    end
  end
endmodule

// File: rtl/bus_addr_resolver.sv
module bus_addr_resolver
  import addr_pkg::*;
#(
  parameter int    ADC_W      = 10,
  parameter int    OFF_W      = 4,
  parameter int    WIN_CYCLES = 50000,
  parameter addr_t DEF_I2C    = 7'h10,
  parameter addr_t DEF_PMB    = 7'h40,
  parameter addr_t TEST_ADDR  = 7'h0A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_pin,
  input  logic [ADC_W-1:0] adc_code,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [15:0]      wr_data,
  output logic [6:0]       i2c_addr_o,
  output logic [6:0]       pmb_addr_o,
  output logic             i2c_en_o,
  output logic             pmb_en_o,
  output logic             i2c_bad_o,
  output logic             pmb_bad_o,
  output logic             clamp_err_o,
  output logic             ready_o,
  output logic [3:0]       offset_o
);
  addr_t            i2c_base_q, pmb_base_q;
  logic             lock_q, opt_q, test_q;
  logic [OFF_W-1:0] ofs_q;
  logic             ready_q;

  addr_t base_v [N_LANE];
  addr_t eff_v  [N_LANE];
  logic [N_LANE-1:0] en_v, bad_v, clamp_v;

  addr_cfg_regs #(.DEF_I2C(DEF_I2C), .DEF_PMB(DEF_PMB)) u_regs (
    .clk(clk), .rst(rst), .test_pin(test_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .i2c_base_q(i2c_base_q), .pmb_base_q(pmb_base_q),
    .lock_q(lock_q), .opt_q(opt_q), .test_q(test_q)
  );

  strap_offset_latch #(.ADC_W(ADC_W), .OFF_W(OFF_W), .WIN_CYCLES(WIN_CYCLES)) u_strap (
    .clk(clk), .rst(rst), .adc_code(adc_code),
    .offset_q(ofs_q), .ready_q(ready_q)
  );

  assign base_v[LANE_PMB] = pmb_base_q;
  assign base_v[LANE_I2C] = i2c_base_q;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    addr_lane #(.OFF_W(OFF_W), .FORCE_ADDR(TEST_ADDR)) u_lane (
      .base(base_v[g]), .offset(ofs_q), .opt_en(opt_q),
      .force_en((g == LANE_I2C) && test_q),
      .eff(eff_v[g]), .en(en_v[g]), .bad(bad_v[g]), .clamp(clamp_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i2c_addr_o  <= '0;
      pmb_addr_o  <= '0;
      i2c_en_o    <= 1'b0;
      pmb_en_o    <= 1'b0;
      i2c_bad_o   <= 1'b0;
      pmb_bad_o   <= 1'b0;
      clamp_err_o <= 1'b0;
      ready_o     <= 1'b0;
      offset_o    <= '0;
    end else begin
      ready_o  <= ready_q;
      offset_o <= 4'(ofs_q);
      if (ready_q) begin
        i2c_addr_o  <= eff_v[LANE_I2C];
        pmb_addr_o  <= eff_v[LANE_PMB];
        i2c_en_o    <= en_v[LANE_I2C];
        pmb_en_o    <= en_v[LANE_PMB];
        i2c_bad_o   <= bad_v[LANE_I2C];
        pmb_bad_o   <= bad_v[LANE_PMB];
        clamp_err_o <= clamp_err_o | (|clamp_v);
      end
    end
  end
endmodule

// File: rtl/bus_addr_resolver_chk.sv
module bus_addr_resolver_chk
  import addr_pkg::*;
#(
  parameter addr_t TEST_ADDR = 7'h0A
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       lock_q,
  input logic       test_q,
  input logic       ready_q,
  input addr_t      i2c_base_q,
  input addr_t      pmb_base_q,
  input logic [3:0] offset_o,
  input logic [6:0] i2c_addr_o,
  input logic [6:0] pmb_addr_o,
  input logic       i2c_en_o,
  input logic       pmb_en_o,
  input logic       i2c_bad_o,
  input logic       pmb_bad_o,
  input logic       clamp_err_o,
  input logic       ready_o
);
  assert_locked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_BASE && lock_q) |=> ($stable(i2c_base_q) && $stable(pmb_base_q)));

  assert_offset_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o)) |-> $stable(offset_o));

  assert_ready_stays_R5: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);

  assert_clamp_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    clamp_err_o |=> clamp_err_o);

  assert_pmb_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !pmb_en_o |-> (pmb_addr_o == '0 && !pmb_bad_o));

  assert_i2c_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !i2c_en_o |-> (i2c_addr_o == '0 && !i2c_bad_o));

  assert_test_force_R10: assert property (@(posedge clk) disable iff (rst)
    (test_q && ready_o) |-> (i2c_addr_o == TEST_ADDR && i2c_en_o && !i2c_bad_o));

  assert_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (!i2c_en_o && !pmb_en_o));
endmodule

bind bus_addr_resolver bus_addr_resolver_chk #(.TEST_ADDR(TEST_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .lock_q(lock_q), .test_q(test_q), .ready_q(ready_q),
  .i2c_base_q(i2c_base_q), .pmb_base_q(pmb_base_q), .offset_o(offset_o),
  .i2c_addr_o(i2c_addr_o), .pmb_addr_o(pmb_addr_o),
  .i2c_en_o(i2c_en_o), .pmb_en_o(pmb_en_o),
  .i2c_bad_o(i2c_bad_o), .pmb_bad_o(pmb_bad_o),
  .clamp_err_o(clamp_err_o), .ready_o(ready_o)
);

// File: tb/sim_bus_addr_resolver.sv
module sim_bus_addr_resolver;
  localparam int WIN   = 64;
  localparam int ADC_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_pin = 1'b0;
  logic [ADC_W-1:0] adc_code = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [6:0] i2c_addr_o, pmb_addr_o;
  logic i2c_en_o, pmb_en_o, i2c_bad_o, pmb_bad_o, clamp_err_o, ready_o;
  logic [3:0] offset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_addr_resolver #(.ADC_W(ADC_W), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst(rst), .test_pin(test_pin), .adc_code(adc_code),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .i2c_addr_o(i2c_addr_o), .pmb_addr_o(pmb_addr_o),
    .i2c_en_o(i2c_en_o), .pmb_en_o(pmb_en_o),
    .i2c_bad_o(i2c_bad_o), .pmb_bad_o(pmb_bad_o),
    .clamp_err_o(clamp_err_o), .ready_o(ready_o), .offset_o(offset_o)
  );

  // {wr_data, i2c, pmb, i2c_en, pmb_en, i2c_bad, pmb_bad}, strap offset 3
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {16'h2050, 7'h23, 7'h53, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h0040, 7'h00, 7'h43, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h1100, 7'h14, 7'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h0107, 7'h04, 7'h0A, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'h090B, 7'h0C, 7'h0E, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h7C05, 7'h7F, 7'h08, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h8080, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Release at a falling edge; stop after WIN falling edges (ready_o still low)
  task automatic do_reset(input logic tp, input int code);
    @(negedge clk);
    rst = 1'b1; test_pin = tp; adc_code = ADC_W'(code);
    repeat (3) @(negedge clk);
    rst = 1'b0; test_pin = 1'b0;
    repeat (WIN) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic map_case(input int code, input int exp);
    do_reset(1'b0, code);
    @(negedge clk);
    chk("R6 offset map", int'(offset_o), exp);
  endtask

  initial begin
    // R11 / R1 / R5: default reset, strap code 0
    do_reset(1'b0, 0);
    chk("R11 not ready at window end", int'(ready_o), 0);
    chk("R11 i2c disabled before ready", int'(i2c_en_o), 0);
    chk("R11 pmb addr zero before ready", int'(pmb_addr_o), 0);
    @(negedge clk);
    chk("R5 ready one edge later", int'(ready_o), 1);
    chk("R1 default i2c", int'(i2c_addr_o), 'h10);
    chk("R1 default pmb", int'(pmb_addr_o), 'h40);
    chk("R6 code 0 offset", int'(offset_o), 0);

    // R1 with offset 3
    do_reset(1'b0, 192);
    @(negedge clk);
    chk("R1 i2c default plus offset", int'(i2c_addr_o), 'h13);
    chk("R1 pmb default plus offset", int'(pmb_addr_o), 'h43);
    // R3 lock default on
    wr(2'd0, 16'h2233);
    chk("R3 locked i2c unchanged", int'(i2c_addr_o), 'h13);
    chk("R3 locked pmb unchanged", int'(pmb_addr_o), 'h43);
    wr(2'd1, 16'h0000);
    // R2 / R8 / R9 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][33:18]);
      chk("R2 i2c addr", int'(i2c_addr_o), int'(VEC[i][17:11]));
      chk("R2 pmb addr", int'(pmb_addr_o), int'(VEC[i][10:4]));
      chk("R8 i2c enable", int'(i2c_en_o), int'(VEC[i][3]));
      chk("R8 pmb enable", int'(pmb_en_o), int'(VEC[i][2]));
      chk("R9 i2c illegal", int'(i2c_bad_o), int'(VEC[i][1]));
      chk("R9 pmb illegal", int'(pmb_bad_o), int'(VEC[i][0]));
    end
    chk("R7 exact 7F no clamp error", int'(clamp_err_o), 0);
    // R4 option off
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h2050);
    chk("R4 i2c no offset", int'(i2c_addr_o), 'h20);
    chk("R4 pmb no offset", int'(pmb_addr_o), 'h50);
    wr(2'd2, 16'h0001);
    chk("R4 i2c offset back", int'(i2c_addr_o), 'h23);
    // R3 relock
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h1111);
    chk("R3 relocked i2c", int'(i2c_addr_o), 'h23);
    chk("R3 relocked pmb", int'(pmb_addr_o), 'h53);
    // R5 late strap change ignored
    adc_code = 10'd1023;
    repeat (10) @(negedge clk);
    chk("R5 offset held", int'(offset_o), 3);
    chk("R5 i2c held", int'(i2c_addr_o), 'h23);

    // R6 thresholds
    map_case(31, 0);
    map_case(32, 1);
    map_case(1023, 15);

    // R7 clamp with offset 8
    do_reset(1'b0, 512);
    @(negedge clk);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h7777);
    chk("R7 77h+8 i2c", int'(i2c_addr_o), 'h7F);
    chk("R7 77h+8 no error", int'(clamp_err_o), 0);
    wr(2'd0, 16'h7878);
    chk("R7 saturate pmb", int'(pmb_addr_o), 'h7F);
    chk("R7 error set", int'(clamp_err_o), 1);
    wr(2'd0, 16'h1010);
    chk("R7 i2c after clamp", int'(i2c_addr_o), 'h18);
    chk("R7 error sticky", int'(clamp_err_o), 1);
    do_reset(1'b0, 512);
    @(negedge clk);
    chk("R7 error cleared by reset", int'(clamp_err_o), 0);

    // R10 test mode
    do_reset(1'b1, 320);
    @(negedge clk);
    chk("R10 i2c forced", int'(i2c_addr_o), 'h0A);
    chk("R10 i2c enabled", int'(i2c_en_o), 1);
    chk("R10 i2c not illegal", int'(i2c_bad_o), 0);
    chk("R10 pmb base cleared", int'(pmb_en_o), 0);
    chk("R10 offset still captured", int'(offset_o), 5);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h2040);
    chk("R10 i2c stays forced", int'(i2c_addr_o), 'h0A);
    chk("R10 option cleared, pmb raw", int'(pmb_addr_o), 'h40);
    do_reset(1'b0, 320);
    @(negedge clk);
    chk("R10 normal reset restores i2c", int'(i2c_addr_o), 'h15);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule